// File: doc/BRIEF.md
# Stochastic Binary Spike-Timing Learning Core

This block is a small unsupervised learning core. A row of one-bit synaptic weights connects N spike input lines to one leaky integrate-and-fire output neuron. On every clock the neuron adds the number of inputs that spike on a conducting synapse, subtracts a programmable leak, and fires once its membrane reaches a programmable threshold. After firing it clears its membrane and stays deaf for a programmable number of cycles.

Every input lane keeps a recency countdown that is reloaded whenever that lane spikes. The cycle after the neuron fires, each synapse is updated by a random decision. A lane that was recently active may be switched on (potentiation) with one tunable probability. A lane that was not recently active may be switched off (depression) with another. Each lane draws its random byte from its own 16-bit LFSR, and the draw is compared against an 8-bit probability setting. A write port loads the whole weight row at once, and the weights are always visible at an output, so the stored state can be preloaded and observed.

Top module: `stdp_learning_core`

## Requirements
- R1: A synchronous active-high `rst` clears all weights, all recency timers, the membrane, the refractory counter and `fire_o`, and reloads every LFSR with its seed.
- R2: A spike on lane i loads that lane's timer with `cfg_win`. Without a spike a nonzero timer decreases by one per cycle. A lane counts as recently active while its registered timer is nonzero, so a spike in cycle c makes the lane recent for learning decisions in cycles c+1 to c+`cfg_win`.
- R3: Outside refractory, the next membrane value is membrane + popcount(`in_spike` & `weight_o`) − `cfg_leak`. It is clamped at 0 from below and at 2^16−1 from above.
- R4: When the next membrane value is at least `cfg_thresh`, `fire_o` is 1 in the following cycle, the membrane is 0 in that same cycle, and the refractory counter is loaded with `cfg_refr`.
- R5: While the refractory counter is nonzero, inputs are ignored, the membrane stays 0 and the counter decreases by one per cycle.
- R6: Without a write, `weight_o` changes only in the cycle after a cycle with `fire_o` = 1.
- R7: In a cycle with `fire_o` = 1, a recently active lane i whose random byte is below `cfg_p_pot` is set to 1 in the next cycle. A lane that is already 1 and recent is never cleared.
- R8: In a cycle with `fire_o` = 1, a lane that is not recent and whose random byte is below `cfg_p_dep` is cleared in the next cycle. A lane that is 0 and not recent is never set.
- R9: Lane i's LFSR is seeded with 16'hACE1 ^ (i·16'h0101). Every cycle it shifts left, with bit 15 ^ bit 13 ^ bit 12 ^ bit 10 entering bit 0. The random byte is LFSR bits [7:0].
- R10: `wr_en` = 1 loads `wr_data` into the weight row for the next cycle and takes priority over learning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_spike | input | N_IN | One spike bit per input lane |
| cfg_win | input | TMR_W | Recency window length in cycles |
| cfg_p_pot | input | PROB_W | Potentiation probability threshold |
| cfg_p_dep | input | PROB_W | Depression probability threshold |
| cfg_leak | input | MEM_W | Leak subtracted per cycle |
| cfg_thresh | input | MEM_W | Firing threshold |
| cfg_refr | input | REFR_W | Refractory length in cycles |
| wr_en | input | 1 | Load the weight row |
| wr_data | input | N_IN | Weight row to load |
| weight_o | output | N_IN | Current weight row |
| membrane_o | output | MEM_W | Current membrane value |
| fire_o | output | 1 | Output spike, one cycle per firing |

## Verification
A wrong recency timer or a wrong LFSR state inside the block stays hidden until the next firing. In the cycle after `fire_o`, `weight_o` then shows the wrong bits, so learning phases must fire often and under many window and probability settings. A wrong weight or membrane shows up sooner. It appears on `membrane_o` one cycle after the next input that touches it, and a wrong refractory count shows up as a nonzero membrane or a shifted `fire_o` within a few cycles. The bench steps a behavioural model alongside the design and compares all three outputs on every cycle, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
    localparam int LFSR_W = 16;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [LFSR_W-1:0] lane_seed(input int lane);
        logic [LFSR_W-1:0] mix;
        mix = LFSR_W'(lane) * 16'h0101;
        return 16'hACE1 ^ mix;
    endfunction
endpackage

// File: rtl/stdp_recency.sv
module stdp_recency #(
    parameter int N_IN  = 8,
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  spike_i,
    input  logic [TMR_W-1:0] win_i,
    output logic [N_IN-1:0]  recent_o
);
    typedef struct packed {
        logic [N_IN-1:0][TMR_W-1:0] tmr;
    } rec_state_t;

    rec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_IN; i++) begin
            if (spike_i[i]) begin
                st_d.tmr[i] = win_i;
            end else if (st_q.tmr[i] != '0) begin
                st_d.tmr[i] = st_q.tmr[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_flag
            assign recent_o[g] = (st_q.tmr[g] != '0);
        end
    endgenerate
endmodule

// File: rtl/stdp_rand_gate.sv
module stdp_rand_gate #(
    parameter int N_IN   = 8,
    parameter int PROB_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PROB_W-1:0] p_pot_i,
    input  logic [PROB_W-1:0] p_dep_i,
    output logic [N_IN-1:0]   pot_ok_o,
    output logic [N_IN-1:0]   dep_ok_o
);
    import stdp_pkg::*;

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_lane
            localparam logic [LFSR_W-1:0] SEED = lane_seed(g);
            logic [LFSR_W-1:0] lfsr_d, lfsr_q;

            always_comb begin
                lfsr_d = lfsr_step(lfsr_q);
            end

            always_ff @(posedge clk) begin
                if (rst) lfsr_q <= SEED;
                else     lfsr_q <= lfsr_d;
            end

            assign pot_ok_o[g] = (lfsr_q[PROB_W-1:0] < p_pot_i);
            assign dep_ok_o[g] = (lfsr_q[PROB_W-1:0] < p_dep_i);
        end
    endgenerate
endmodule

// File: rtl/stdp_lif_neuron.sv
module stdp_lif_neuron #(
    parameter int N_IN   = 8,
    parameter int MEM_W  = 16,
    parameter int REFR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   drive_i,
    input  logic [MEM_W-1:0]  leak_i,
    input  logic [MEM_W-1:0]  thresh_i,
    input  logic [REFR_W-1:0] refr_i,
    output logic              fire_o,
    output logic [MEM_W-1:0]  mem_o,
    output logic              refr_busy_o
);
    localparam int CNT_W = $clog2(N_IN + 1);
    localparam logic [MEM_W:0] MEM_MAX = {1'b0, {MEM_W{1'b1}}};

    typedef struct packed {
        logic [MEM_W-1:0]  mem;
        logic [REFR_W-1:0] refr;
        logic              fire;
    } lif_state_t;

    lif_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt;
    logic [MEM_W:0]   acc;
    logic [MEM_W:0]   lvl;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N_IN; i++) begin
            cnt = cnt + CNT_W'(drive_i[i]);
        end
        acc = {1'b0, st_q.mem} + (MEM_W+1)'(cnt);
        if (acc >= {1'b0, leak_i}) lvl = acc - {1'b0, leak_i};
        else                       lvl = '0;
        if (lvl > MEM_MAX) lvl = MEM_MAX;

        st_d = st_q;
        if (st_q.refr != '0) begin
            st_d.refr = st_q.refr - 1'b1;
            st_d.mem  = '0;
            st_d.fire = 1'b0;
        end else if (lvl >= {1'b0, thresh_i}) begin
            st_d.mem  = '0;
            st_d.refr = refr_i;
            st_d.fire = 1'b1;
        end else begin
            st_d.mem  = lvl[MEM_W-1:0];
            st_d.fire = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fire_o      = st_q.fire;
    assign mem_o       = st_q.mem;
    assign refr_busy_o = (st_q.refr != '0);
endmodule

// File: rtl/stdp_learning_core.sv
module stdp_learning_core #(
    parameter int N_IN   = 8,
    parameter int TMR_W  = 8,
    parameter int PROB_W = 8,
    parameter int MEM_W  = 16,
    parameter int REFR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   in_spike,
    input  logic [TMR_W-1:0]  cfg_win,
    input  logic [PROB_W-1:0] cfg_p_pot,
    input  logic [PROB_W-1:0] cfg_p_dep,
    input  logic [MEM_W-1:0]  cfg_leak,
    input  logic [MEM_W-1:0]  cfg_thresh,
    input  logic [REFR_W-1:0] cfg_refr,
    input  logic              wr_en,
    input  logic [N_IN-1:0]   wr_data,
    output logic [N_IN-1:0]   weight_o,
    output logic [MEM_W-1:0]  membrane_o,
    output logic              fire_o
);
    typedef struct packed {
        logic [N_IN-1:0] weight;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [N_IN-1:0] recent_v;
    logic [N_IN-1:0] pot_ok;
    logic [N_IN-1:0] dep_ok;
    logic            fire;
    logic            refr_busy;

    stdp_recency #(.N_IN(N_IN), .TMR_W(TMR_W)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .spike_i  (in_spike),
        .win_i    (cfg_win),
        .recent_o (recent_v)
    );

    stdp_rand_gate #(.N_IN(N_IN), .PROB_W(PROB_W)) u_rng (
        .clk      (clk),
        .rst      (rst),
        .p_pot_i  (cfg_p_pot),
        .p_dep_i  (cfg_p_dep),
        .pot_ok_o (pot_ok),
        .dep_ok_o (dep_ok)
    );

    stdp_lif_neuron #(.N_IN(N_IN), .MEM_W(MEM_W), .REFR_W(REFR_W)) u_lif (
        .clk         (clk),
        .rst         (rst),
        .drive_i     (in_spike & st_q.weight),
        .leak_i      (cfg_leak),
        .thresh_i    (cfg_thresh),
        .refr_i      (cfg_refr),
        .fire_o      (fire),
        .mem_o       (membrane_o),
        .refr_busy_o (refr_busy)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.weight = wr_data;
        end else if (fire) begin
            for (int i = 0; i < N_IN; i++) begin
                if (recent_v[i] && pot_ok[i])       st_d.weight[i] = 1'b1;
                else if (!recent_v[i] && dep_ok[i]) st_d.weight[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign weight_o = st_q.weight;
    assign fire_o   = fire;
endmodule

// File: rtl/stdp_core_checker.sv
module stdp_core_checker #(
    parameter int N_IN  = 8,
    parameter int MEM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fire_i,
    input logic             wr_en_i,
    input logic [N_IN-1:0]  wr_data_i,
    input logic [N_IN-1:0]  weight_i,
    input logic [MEM_W-1:0] mem_i,
    input logic [N_IN-1:0]  recent_i,
    input logic             refr_busy_i
);
    // R1: reset clears weights and membrane
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (weight_i == '0 && mem_i == '0 && !fire_i));

    // R4: a firing cycle shows an empty membrane
    p_fire_resets_r4: assert property (@(posedge clk) disable iff (rst)
        fire_i |-> (mem_i == '0));

    // R5: refractory keeps the membrane at zero
    p_refr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        refr_busy_i |=> (mem_i == '0));

    // R6: no firing and no write leaves weights alone
    p_weight_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!fire_i && !wr_en_i) |=> $stable(weight_i));

    // R7: recent lanes that are on stay on
    p_pot_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (fire_i && !wr_en_i) |=> ((~weight_i & $past(weight_i & recent_i)) == '0));

    // R8: non-recent lanes that are off stay off
    p_dep_no_set_r8: assert property (@(posedge clk) disable iff (rst)
        (fire_i && !wr_en_i) |=> ((weight_i & ~$past(weight_i) & ~$past(recent_i)) == '0));

    // R10: a write lands next cycle
    p_write_load_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (weight_i == $past(wr_data_i)));
endmodule

bind stdp_learning_core stdp_core_checker #(.N_IN(N_IN), .MEM_W(MEM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fire_i      (fire_o),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .weight_i    (weight_o),
    .mem_i       (membrane_o),
    .recent_i    (recent_v),
    .refr_busy_i (refr_busy)
);

// File: tb/stdp_learning_core_test.sv
module stdp_learning_core_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] in_spike = '0;
    logic [7:0]  cfg_win = 8'd4;
    logic [7:0]  cfg_p_pot = '0;
    logic [7:0]  cfg_p_dep = '0;
    logic [15:0] cfg_leak = '0;
    logic [15:0] cfg_thresh = 16'd1000;
    logic [7:0]  cfg_refr = '0;
    logic        wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] weight_o;
    logic [15:0] membrane_o;
    logic        fire_o;

    always #2.5 clk = ~clk;

    stdp_learning_core uut (
        .clk(clk), .rst(rst), .in_spike(in_spike), .cfg_win(cfg_win),
        .cfg_p_pot(cfg_p_pot), .cfg_p_dep(cfg_p_dep), .cfg_leak(cfg_leak),
        .cfg_thresh(cfg_thresh), .cfg_refr(cfg_refr), .wr_en(wr_en),
        .wr_data(wr_data), .weight_o(weight_o), .membrane_o(membrane_o),
        .fire_o(fire_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int fires = 0;
    bit done = 0;

    // behavioural reference
    bit [N-1:0] m_w;
    int         m_tmr[N];
    bit [15:0]  m_lfsr[N];
    int         m_mem;
    int         m_refr;
    bit         m_fire;
    bit         m_valid = 0;

    always @(posedge clk) begin
        bit [N-1:0] nw;
        bit nf;
        int cnt, lvl;
        if (rst) begin
            m_w = '0; m_mem = 0; m_refr = 0; m_fire = 0; m_valid = 1;
            for (int i = 0; i < N; i++) begin
                m_tmr[i] = 0;
                m_lfsr[i] = 16'hACE1 ^ (16'(i) * 16'h0101);
            end
        end else begin
            nw = m_w;
            if (wr_en) nw = wr_data;
            else if (m_fire) begin
                for (int i = 0; i < N; i++) begin
                    if (m_tmr[i] != 0 && int'(m_lfsr[i][7:0]) < int'(cfg_p_pot)) nw[i] = 1;
                    else if (m_tmr[i] == 0 && int'(m_lfsr[i][7:0]) < int'(cfg_p_dep)) nw[i] = 0;
                end
            end
            if (m_refr > 0) begin
                m_refr = m_refr - 1; m_mem = 0; nf = 0;
            end else begin
                cnt = 0;
                for (int i = 0; i < N; i++) if (in_spike[i] && m_w[i]) cnt++;
                lvl = m_mem + cnt - int'(cfg_leak);
                if (lvl < 0) lvl = 0;
                if (lvl > 65535) lvl = 65535;
                if (lvl >= int'(cfg_thresh)) begin
                    nf = 1; m_mem = 0; m_refr = int'(cfg_refr);
                end else begin
                    nf = 0; m_mem = lvl;
                end
            end
            for (int i = 0; i < N; i++) begin
                if (in_spike[i]) m_tmr[i] = int'(cfg_win);
                else if (m_tmr[i] > 0) m_tmr[i] = m_tmr[i] - 1;
                m_lfsr[i] = {m_lfsr[i][14:0], m_lfsr[i][15] ^ m_lfsr[i][13] ^ m_lfsr[i][12] ^ m_lfsr[i][10]};
            end
            m_w = nw; m_fire = nf;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid && !rst && !done) begin
            chk(weight_o == m_w, "R2 R7 R8 R9 weight row", int'(weight_o), int'(m_w));
            chk(membrane_o == 16'(m_mem), "R3 R5 membrane", int'(membrane_o), m_mem);
            chk(fire_o == m_fire, "R4 fire", int'(fire_o), int'(m_fire));
            if (fire_o) fires++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preload(input logic [N-1:0] v);
        wr_en = 1; wr_data = v;
        step(1);
        wr_en = 0;
    endtask

    initial begin
        int f0;
        step(3);
        rst = 0;
        step(1);
        // R1
        chk(weight_o == '0 && membrane_o == '0 && !fire_o, "R1 reset state",
            int'({weight_o, membrane_o}), 0);

        // R10 preload
        preload(8'hFF);
        chk(weight_o == 8'hFF, "R10 write", int'(weight_o), 'hFF);

        // R3 integration and leak
        cfg_leak = 16'd1; cfg_thresh = 16'd1000;
        in_spike = 8'h07;
        step(1);
        in_spike = 8'h00;
        chk(membrane_o == 16'd2, "R3 integrate", int'(membrane_o), 2);
        cfg_leak = 16'd5;
        step(1);
        chk(membrane_o == 16'd0, "R3 leak floor", int'(membrane_o), 0);

        // R4 / R5 / R6 fire with refractory, probabilities zero
        cfg_leak = 0; cfg_thresh = 16'd4; cfg_refr = 8'd5;
        cfg_p_pot = 0; cfg_p_dep = 0;
        in_spike = 8'hFF;
        step(1);
        chk(fire_o == 1'b1 && membrane_o == 0, "R4 fire pulse", int'(fire_o), 1);
        for (int k = 1; k <= 5; k++) begin
            step(1);
            chk(membrane_o == 0, "R5 refractory hold", int'(membrane_o), 0);
            chk(fire_o == 0, "R5 no refire", int'(fire_o), 0);
        end
        chk(weight_o == 8'hFF, "R6 zero probability keeps row", int'(weight_o), 'hFF);
        in_spike = 0; cfg_refr = 0;
        step(8);

        // R2 expired window versus fresh window
        cfg_win = 8'd2; cfg_p_pot = 8'hFF; cfg_p_dep = 0; cfg_thresh = 16'd1;
        preload(8'h80);
        step(4);
        in_spike = 8'h01; step(1);
        in_spike = 8'h00; step(2);
        in_spike = 8'h80; step(1);
        in_spike = 8'h00; step(2);
        chk(weight_o[0] == 1'b0, "R2 expired lane not set", int'(weight_o[0]), 0);
        step(4);
        in_spike = 8'h01; step(1);
        in_spike = 8'h80; step(1);
        in_spike = 8'h00; step(2);
        chk(weight_o[0] == m_w[0], "R2 recent lane potentiation", int'(weight_o[0]), int'(m_w[0]));

        // R7 potentiation, R8 depression
        step(4);
        preload(8'h80);
        cfg_win = 8'd6;
        in_spike = 8'h8F; step(1);
        in_spike = 8'h00; step(2);
        chk(weight_o[7] == 1'b1, "R7 on lane stays on", int'(weight_o[7]), 1);
        chk(weight_o == m_w, "R7 set pattern", int'(weight_o), int'(m_w));
        step(10);
        preload(8'hFF);
        cfg_p_pot = 0; cfg_p_dep = 8'hFF;
        in_spike = 8'h80; step(1);
        in_spike = 8'h00; step(2);
        chk(weight_o == m_w, "R8 clear pattern", int'(weight_o), int'(m_w));
        chk(weight_o[7] == 1'b1, "R8 recent lane kept", int'(weight_o[7]), 1);

        // random learning phases (R9 via weight evolution)
        f0 = fires;
        for (int ph = 0; ph < 4; ph++) begin
            cfg_win    = 8'(2 + ph * 3);
            cfg_p_pot  = 8'(60 + ph * 50);
            cfg_p_dep  = 8'(200 - ph * 45);
            cfg_leak   = 16'(ph % 2);
            cfg_thresh = 16'(3 + ph);
            cfg_refr   = 8'(ph);
            preload(8'(8'hA5 ^ (ph * 8'h3C)));
            for (int c = 0; c < 1500; c++) begin
                for (int i = 0; i < N; i++) in_spike[i] = ($urandom_range(99) < 30);
                if ($urandom_range(299) == 0) begin
                    wr_en = 1; wr_data = 8'($urandom);
                end else wr_en = 0;
                step(1);
            end
            wr_en = 0;
        end
        chk(fires > f0, "R4 random phases fired", fires - f0, 1);

        step(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule